// File: doc/BRIEF.md
# Wide-to-Narrow Random Word Buffer

This block sits between a random-number generator that produces very wide words and a consumer that wants them 32 bits at a time. The generator presents a 512-bit word with a single-cycle valid strobe. The block raises a request line whenever it has a free slot, so the generator knows that it may send another word. Up to four wide words are held in first-in, first-out order.

On the consumer side the block shows one 32-bit slice of the oldest wide word, together with a flag that says data is present. Each acknowledge from the consumer moves to the next slice. After the last slice of an entry has been taken, the entry is freed and the next one is shown. A flush input drops everything held at once, for example when the generator is reseeded and stale output must not leak.

Top module: `wide_word_narrow_fifo`

## Requirements
- R1: In the cycle after a synchronous reset, `out_valid` is 0 and `want_more` is 1.
- R2: `want_more` is 1 exactly when fewer than DEPTH (4) wide words are held.
- R3: An `in_valid` pulse while `want_more` is 1 and `flush` is 0 stores `in_data`, and `out_valid` is 1 from the next cycle.
- R4: An `in_valid` pulse while the buffer holds DEPTH words is ignored. The held words, their order and their count stay unchanged.
- R5: Within one wide word the slices come out from bits 511:480 first, down to bits 31:0 last.
- R6: The slice advances by one for each cycle in which `out_ack` is 1, `out_ack` was 0 in the previous cycle, and `out_valid` is 1. Holding `out_ack` high advances it only once.
- R7: After the 16th slice of an entry is taken, the next wide word is shown from its first slice, in arrival order, and one slot becomes free (`want_more` rises if the buffer was full).
- R8: `out_ack` while `out_valid` is 0 has no effect. A word written later is still shown from its first slice.
- R9: A one-cycle `flush` empties the buffer. In the next cycle `out_valid` is 0 and `want_more` is 1. A write in the same cycle as the flush is dropped, and the next word stored is shown from its first slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 512 | Wide word from the generator |
| in_valid | input | 1 | One-cycle strobe that writes `in_data` |
| flush | input | 1 | Drops all held data |
| want_more | output | 1 | A free slot is available |
| out_valid | output | 1 | `out_data` holds a valid slice |
| out_data | output | 32 | Current 32-bit slice |
| out_ack | input | 1 | Consumer takes the current slice (rising level counts) |

## Verification
The assertions assume that the generator strobes `in_valid` for one cycle at a time. They also assume that the consumer treats `out_ack` as a level whose low-to-high change is meaningful, so a held acknowledge must never count twice. The stimulus drives every input at the falling edge. It always drops `out_ack` for at least one full cycle between slices, except in the one deliberate hold test. A write is sent while the buffer is full only to check that it is ignored, and a write is sent together with `flush` only to check that it is dropped.

// File: rtl/wnf_pkg.sv
package wnf_pkg;
  parameter int WNF_IN_W  = 512;
  parameter int WNF_OUT_W = 32;
  parameter int WNF_DEPTH = 4;
endpackage

// File: rtl/wnf_mem.sv
module wnf_mem #(
  parameter int W     = 512,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/wnf_occ.sv
module wnf_occ #(
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          full,
  output logic          empty
);
  logic [CW-1:0] count;
  logic          pop;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign push  = push_req & ~full & ~flush;
  assign pop   = pop_req & ~empty & ~flush;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2: occupancy never exceeds the number of slots
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R4: a write against a full buffer leaves it full and the write slot unmoved
  a_r4_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (full && push_req && !pop_req && !flush) |=> (full && $stable(wr_ptr)));

  // R9: a flush leaves the buffer empty
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && wr_ptr == '0 && rd_ptr == '0));
endmodule

// File: rtl/wnf_slicer.sv
module wnf_slicer #(
  parameter int IN_W   = 512,
  parameter int OUT_W  = 32,
  localparam int NSL   = IN_W / OUT_W,
  localparam int SW    = (NSL > 1) ? $clog2(NSL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             have_data,
  input  logic             ack,
  input  logic [IN_W-1:0]  entry,
  output logic [OUT_W-1:0] word,
  output logic             entry_done
);
  logic [SW-1:0]    sel;
  logic             ack_q;
  logic             step;
  logic [OUT_W-1:0] slices [NSL];

  // slice 0 is the most significant part of the entry
  for (genvar g = 0; g < NSL; g++) begin : g_slice
    assign slices[g] = entry[(NSL-1-g)*OUT_W +: OUT_W];
  end

  assign step       = ack & ~ack_q & have_data;
  assign entry_done = step && (sel == SW'(NSL - 1));
  assign word       = slices[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= '0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= ack;
      if (flush)           sel <= '0;
      else if (entry_done) sel <= '0;
      else if (step)       sel <= sel + 1'b1;
    end
  end

  // R6: a held acknowledge does not move the slice again
  a_r6_held_ack_once: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_q && !flush) |=> $stable(sel));

  // R8: with nothing buffered the slice pointer rests at the first slice
  a_r8_idle_at_first: assert property (@(posedge clk) disable iff (rst)
    !have_data |-> sel == '0);
endmodule

// File: rtl/wide_word_narrow_fifo.sv
module wide_word_narrow_fifo
  import wnf_pkg::*;
#(
  parameter int IN_W  = WNF_IN_W,
  parameter int OUT_W = WNF_OUT_W,
  parameter int DEPTH = WNF_DEPTH,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_valid,
  input  logic             flush,
  output logic             want_more,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  input  logic             out_ack
);
  logic          push, full, empty, entry_done;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [IN_W-1:0] head;

  wnf_occ #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst(rst), .flush(flush),
    .push_req(in_valid), .pop_req(entry_done),
    .push(push), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .full(full), .empty(empty)
  );

  wnf_mem #(.W(IN_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(push), .waddr(wr_ptr), .wdata(in_data),
    .raddr(rd_ptr), .rdata(head)
  );

  wnf_slicer #(.IN_W(IN_W), .OUT_W(OUT_W)) u_slicer (
    .clk(clk), .rst(rst), .flush(flush),
    .have_data(~empty), .ack(out_ack), .entry(head),
    .word(out_data), .entry_done(entry_done)
  );

  assign want_more = ~full;
  assign out_valid = ~empty;

  // R3: an accepted write makes data visible on the next cycle
  a_r3_valid_after_write: assert property (@(posedge clk) disable iff (rst)
    (in_valid && want_more && !flush) |=> out_valid);

  // R9: after a flush the producer is asked for data again
  a_r9_flush_requests: assert property (@(posedge clk) disable iff (rst)
    flush |=> (want_more && !out_valid));
endmodule

// File: tb/wide_word_narrow_fifo_bench.sv
module wide_word_narrow_fifo_bench;
  localparam int IN_W = 512, OUT_W = 32, NSL = IN_W / OUT_W, DEPTH = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [IN_W-1:0]  in_data = '0;
  logic             in_valid = 1'b0;
  logic             flush = 1'b0;
  logic             want_more;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;
  logic             out_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int mcount = 0;
  int taken  = 0;
  logic [OUT_W-1:0] q [$];

  always #10 clk = ~clk;

  wide_word_narrow_fifo u_wide_word_narrow_fifo (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .flush(flush), .want_more(want_more), .out_valid(out_valid),
    .out_data(out_data), .out_ack(out_ack)
  );

  function automatic logic [OUT_W-1:0] slice_of(input int base, input int k);
    return OUT_W'(base * 256 + k) ^ 32'h5A00_0000;
  endfunction

  function automatic logic [IN_W-1:0] make_wide(input int base);
    logic [IN_W-1:0] w;
    for (int k = 0; k < NSL; k++) w[(NSL-1-k)*OUT_W +: OUT_W] = slice_of(base, k);
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [OUT_W-1:0] act,
                       input logic [OUT_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: one strobe, scoreboard updated only if the slot is free
  task automatic push_wide(input int base);
    in_data  = make_wide(base);
    in_valid = 1'b1;
    if (mcount < DEPTH) begin
      for (int k = 0; k < NSL; k++) q.push_back(slice_of(base, k));
      mcount++;
    end
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: compare the shown slice with the scoreboard, then acknowledge
  task automatic take_word(input string req);
    logic [OUT_W-1:0] exp;
    check(out_valid == 1'b1, req, OUT_W'(out_valid), 1);
    exp = (q.size() > 0) ? q.pop_front() : '0;
    check(out_data == exp, req, out_data, exp);
    out_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ack = 1'b0;
    @(posedge clk); @(negedge clk);
    taken++;
    if (taken == NSL) begin taken = 0; mcount--; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    check(out_valid == 1'b0, "R1", OUT_W'(out_valid), 0);
    check(want_more == 1'b1, "R1", OUT_W'(want_more), 1);

    // R8: acknowledge while empty
    out_ack = 1'b1; @(posedge clk); @(negedge clk);
    out_ack = 1'b0; @(posedge clk); @(negedge clk);
    check(out_valid == 1'b0, "R8", OUT_W'(out_valid), 0);

    // R3 / R2
    push_wide(16'h0100);
    check(out_valid == 1'b1, "R3", OUT_W'(out_valid), 1);
    check(want_more == 1'b1, "R2", OUT_W'(want_more), 1);
    push_wide(16'h0200);
    push_wide(16'h0300);
    push_wide(16'h0400);
    check(want_more == 1'b0, "R2", OUT_W'(want_more), 0);

    // R4: write while full is ignored
    push_wide(16'h0999);
    check(want_more == 1'b0, "R4", OUT_W'(want_more), 0);

    // R6: held acknowledge advances once (R8 also: first slice shown)
    begin
      logic [OUT_W-1:0] exp;
      exp = q.pop_front();
      check(out_data == exp, "R8", out_data, exp);
      out_ack = 1'b1;
      repeat (3) begin @(posedge clk); @(negedge clk); end
      out_ack = 1'b0;
      @(posedge clk); @(negedge clk);
      taken = 1;
    end
    take_word("R6");

    // R5: rest of the first entry, most significant first
    for (int i = 0; i < NSL - 2; i++) take_word("R5");
    check(want_more == 1'b1, "R7", OUT_W'(want_more), 1);

    // R7: refill and drain in arrival order
    push_wide(16'h0500);
    while (q.size() > 0) take_word("R7");
    check(out_valid == 1'b0, "R4", OUT_W'(out_valid), 0);
    check(want_more == 1'b1, "R2", OUT_W'(want_more), 1);

    // R9: flush mid-entry together with a write
    push_wide(16'h0600);
    push_wide(16'h0650);
    take_word("R9");
    take_word("R9");
    take_word("R9");
    flush = 1'b1; in_data = make_wide(16'h0777); in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    check(out_valid == 1'b0, "R9", OUT_W'(out_valid), 0);
    check(want_more == 1'b1, "R9", OUT_W'(want_more), 1);
    q.delete(); mcount = 0; taken = 0;
    push_wide(16'h0700);
    for (int i = 0; i < NSL; i++) take_word("R9");
    check(out_valid == 1'b0, "R9", OUT_W'(out_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end
endmodule